// File: doc/BRIEF.md
# Processor Status Register Unit with Per-Mode Save Banks

This block holds the 32-bit live status word of a processor core, together with five saved copies, one for each exception mode. The live word combines four condition flags, a sticky saturation flag, two interrupt mask bits, an instruction-state bit and a five-bit mode field. All other bit positions always read as zero.

Four request sources update the word:

- the ALU, with new condition flags;
- a move-to-status port, which writes selected fields of either the live word or the saved copy of the current mode;
- exception entry, which saves the live word into the bank of the target mode and switches into that mode;
- exception return, which restores the live word from the bank of the current mode.

Every request is a single-cycle strobe. None is ever back-pressured. A request that is not honoured is dropped, not delayed. All updates take effect at the next rising clock edge. The outputs come straight from registers through read multiplexers.

Top module: `stat_unit`

## Requirements
- R1: Bit layout is N=31, Z=30, C=29, V=28, Q=27, I=7, F=6, T=5 and mode[4:0]=bits 4..0. Bits 26..8 of the live word and of every saved word always read zero.
- R2: Reset gives a live word of 0x000000D3 (supervisor, I=1, F=1, T=0, all flags zero) and clears every saved word.
- R3: A flag update replaces bits 31..28 with `flg_nzcv`. Q becomes Q OR `flg_qset`, so a flag update never clears Q.
- R4: A move to the live word uses `mv_fields`. Bit 1 selects the flag byte (bits 31..24) and bit 0 selects the control byte (bits 7..0). The control byte part is ignored while the mode is user (10000).
- R5: A move with `mv_saved`=1 writes the selected fields of the saved word of the current mode. In user or system (11111) mode it is ignored.
- R6: Exception entry with a target of fast (10001), normal (10010), supervisor (10011), abort (10111) or undefined (11011) does three things. It copies the live word into that mode's saved word. It sets the mode field to the target. It clears T and sets I, and it also sets F when the target is fast. Any other target is ignored.
- R7: Exception return loads the live word from the saved word of the current mode. In user or system mode it is ignored.
- R8: `saved_o` shows the saved word of the current mode, and zero in user or system mode.
- R9: `irq_en` equals NOT I and `fiq_en` equals NOT F of the live word.
- R10: When requests coincide, the priority is: valid entry, then honoured return, then move, then flag update. Lower-priority requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flg_upd | input | 1 | Flag update strobe from the ALU |
| flg_nzcv | input | 4 | New N, Z, C, V values |
| flg_qset | input | 1 | Saturation occurred; sets Q |
| mv_we | input | 1 | Move-to-status strobe |
| mv_saved | input | 1 | 1 targets the saved word of the current mode |
| mv_fields | input | 2 | Field select: bit 1 flag byte, bit 0 control byte |
| mv_data | input | 32 | Value to move |
| exc_entry | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode code for entry |
| exc_ret | input | 1 | Exception return strobe |
| status_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved word of the current mode |
| irq_en | output | 1 | Normal interrupt enabled |
| fiq_en | output | 1 | Fast interrupt enabled |

## Verification
The assertions assume every request strobe and data input is a known value on each clock edge after reset. `exc_mode` may carry any five-bit code, including ones that are not exception modes. The stimulus asserts each strobe for exactly one cycle and returns every input to zero between requests. It includes deliberately illegal entry targets and moves with reserved bits set, which exercise the ignore and masking rules without leaving these assumptions. The coincident-request cases are the only cycles where more than one strobe is high.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 5;
  localparam int NBANK  = 5;
  localparam int IDX_W  = $clog2(NBANK + 1);

  localparam int BIT_Q = 27;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FST = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_NRM = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SUP = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [WORD_W-1:0] LIVE_MASK  = 32'hF800_00FF;
  localparam logic [WORD_W-1:0] FLAG_BYTE  = 32'hFF00_0000;
  localparam logic [WORD_W-1:0] CTRL_BYTE  = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_00D3;

  localparam logic [IDX_W-1:0] NO_BANK = '1;

  function automatic logic [IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FST: bank_of = IDX_W'(0);
      MODE_NRM: bank_of = IDX_W'(1);
      MODE_SUP: bank_of = IDX_W'(2);
      MODE_ABT: bank_of = IDX_W'(3);
      MODE_UND: bank_of = IDX_W'(4);
      default:  bank_of = NO_BANK;
    endcase
  endfunction
endpackage

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int N = NBANK,
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_mask,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] bank_q [N];

  for (genvar g = 0; g < N; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        bank_q[g] <= ((bank_q[g] & ~wr_mask) | (wr_data & wr_mask)) & W'(LIVE_MASK);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == IDX_W'(i)) rd_data = bank_q[i];
  end

  // R1
  bank_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[26:8] == '0);
endmodule

// File: rtl/stat_core.sv
module stat_core
  import stat_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_ok,
  input  logic [MODE_W-1:0] entry_mode,
  input  logic              ret_ok,
  input  logic [W-1:0]      ret_word,
  input  logic              mv_ok,
  input  logic [W-1:0]      mv_mask,
  input  logic [W-1:0]      mv_word,
  input  logic              flg_ok,
  input  logic [3:0]        flg_nzcv,
  input  logic              flg_qset,
  output logic [W-1:0]      cur
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = cur;
    if (entry_ok) begin
      nxt[MODE_W-1:0] = entry_mode;
      nxt[BIT_T]      = 1'b0;
      nxt[BIT_I]      = 1'b1;
      if (entry_mode == MODE_FST) nxt[BIT_F] = 1'b1;
    end else if (ret_ok) begin
      nxt = ret_word;
    end else if (mv_ok) begin
      nxt = (cur & ~mv_mask) | (mv_word & mv_mask);
    end else if (flg_ok) begin
      nxt[31:28] = flg_nzcv;
      nxt[BIT_Q] = cur[BIT_Q] | flg_qset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= W'(RESET_WORD);
    else        cur <= nxt & W'(LIVE_MASK);
  end

  // R1
  live_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur[26:8] == '0);
  // R3
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur[BIT_Q] && !mv_ok && !ret_ok) |=> cur[BIT_Q]);
  // R6
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_ok |=> (cur[MODE_W-1:0] == $past(entry_mode)) && cur[BIT_I] && !cur[BIT_T]);
endmodule

// File: rtl/stat_unit.sv
module stat_unit
  import stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flg_upd,
  input  logic [3:0]  flg_nzcv,
  input  logic        flg_qset,
  input  logic        mv_we,
  input  logic        mv_saved,
  input  logic [1:0]  mv_fields,
  input  logic [31:0] mv_data,
  input  logic        exc_entry,
  input  logic [4:0]  exc_mode,
  input  logic        exc_ret,
  output logic [31:0] status_o,
  output logic [31:0] saved_o,
  output logic        irq_en,
  output logic        fiq_en
);
  logic [IDX_W-1:0] cur_idx, tgt_idx, wr_idx;
  logic             entry_ok, ret_ok, mv_ok, flg_ok;
  logic             mv_cur_ok, mv_sav_ok, bank_we;
  logic [31:0]      field_mask, bank_mask, bank_data;
  logic             in_user;

  assign cur_idx  = bank_of(status_o[MODE_W-1:0]);
  assign tgt_idx  = bank_of(exc_mode);
  assign in_user  = status_o[MODE_W-1:0] == MODE_USR;

  assign entry_ok  = exc_entry && (tgt_idx != NO_BANK);
  assign ret_ok    = exc_ret && (cur_idx != NO_BANK) && !entry_ok;
  assign mv_ok     = mv_we && !entry_ok && !ret_ok;
  assign mv_cur_ok = mv_ok && !mv_saved;
  assign mv_sav_ok = mv_ok && mv_saved && (cur_idx != NO_BANK);
  assign flg_ok    = flg_upd && !entry_ok && !ret_ok && !mv_ok;

  always_comb begin
    field_mask = '0;
    if (mv_fields[1]) field_mask = field_mask | FLAG_BYTE;
    if (mv_fields[0] && (mv_saved || !in_user)) field_mask = field_mask | CTRL_BYTE;
  end

  assign bank_we   = entry_ok || mv_sav_ok;
  assign wr_idx    = entry_ok ? tgt_idx : cur_idx;
  assign bank_mask = entry_ok ? '1 : field_mask;
  assign bank_data = entry_ok ? status_o : mv_data;

  stat_bank #(.N(NBANK), .W(WORD_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .wr_idx  (wr_idx),
    .wr_mask (bank_mask),
    .wr_data (bank_data),
    .rd_idx  (cur_idx),
    .rd_data (saved_o)
  );

  stat_core #(.W(WORD_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_ok   (entry_ok),
    .entry_mode (exc_mode),
    .ret_ok     (ret_ok),
    .ret_word   (saved_o),
    .mv_ok      (mv_cur_ok),
    .mv_mask    (field_mask),
    .mv_word    (mv_data),
    .flg_ok     (flg_ok),
    .flg_nzcv   (flg_nzcv),
    .flg_qset   (flg_qset),
    .cur        (status_o)
  );

  assign irq_en = ~status_o[BIT_I];
  assign fiq_en = ~status_o[BIT_F];

  // R6
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_ok |=> saved_o == $past(status_o));
  // R7
  ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && (cur_idx == NO_BANK) && !exc_entry && !mv_we && !flg_upd) |=> $stable(status_o));
  // R8
  saved_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == NO_BANK) |-> saved_o == '0);
  // R4
  user_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_user && !exc_entry && !exc_ret && !flg_upd) |=> status_o[7:0] == $past(status_o[7:0]));
endmodule

// File: tb/tb_stat_unit.sv
`timescale 1ns/1ps
module tb_stat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flg_upd, flg_qset, mv_we, mv_saved, exc_entry, exc_ret;
  logic [3:0]  flg_nzcv;
  logic [1:0]  mv_fields;
  logic [31:0] mv_data;
  logic [4:0]  exc_mode;
  logic [31:0] status_o, saved_o;
  logic        irq_en, fiq_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_unit dut (
    .clk(clk), .rst_n(rst_n), .flg_upd(flg_upd), .flg_nzcv(flg_nzcv),
    .flg_qset(flg_qset), .mv_we(mv_we), .mv_saved(mv_saved),
    .mv_fields(mv_fields), .mv_data(mv_data), .exc_entry(exc_entry),
    .exc_mode(exc_mode), .exc_ret(exc_ret), .status_o(status_o),
    .saved_o(saved_o), .irq_en(irq_en), .fiq_en(fiq_en)
  );

  // op: 0 flag update (a[3:0]=nzcv, b[0]=qset), 1 move live, 2 move saved
  //     (b[1:0]=fields), 3 entry (b=mode), 4 return
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [4:0]  b;
    logic [31:0] exp_s;
    logic [31:0] exp_sv;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{3'd0, 32'h0000000A, 5'd1,       32'hA80000D3, 32'h00000000}, // R3
    '{3'd0, 32'h00000005, 5'd0,       32'h580000D3, 32'h00000000}, // R3 Q kept
    '{3'd3, 32'h0,        5'b10010,   32'h580000D2, 32'h580000D3}, // R6
    '{3'd1, 32'hF0000000, 5'd2,       32'hF00000D2, 32'h580000D3}, // R4
    '{3'd2, 32'h2FFFFF10, 5'd3,       32'hF00000D2, 32'h28000010}, // R5 R1
    '{3'd4, 32'h0,        5'd0,       32'h28000010, 32'h00000000}, // R7 R8
    '{3'd1, 32'h000000D3, 5'd3,       32'h00000010, 32'h00000000}, // R4 user
    '{3'd4, 32'h0,        5'd0,       32'h00000010, 32'h00000000}, // R7 ignored
    '{3'd3, 32'h0,        5'b10001,   32'h000000D1, 32'h00000010}, // R6 fast
    '{3'd3, 32'h0,        5'b10111,   32'h000000D7, 32'h000000D1}, // R6 abort
    '{3'd1, 32'h0000003B, 5'd1,       32'h0000003B, 32'h00000000}, // R4 ctrl
    '{3'd0, 32'h00000001, 5'd0,       32'h1000003B, 32'h00000000}, // R3
    '{3'd3, 32'h0,        5'b10000,   32'h1000003B, 32'h00000000}, // R6 bad target
    '{3'd2, 32'hFF0000FF, 5'd3,       32'h1000003B, 32'hF80000FF}, // R5 R1
    '{3'd4, 32'h0,        5'd0,       32'hF80000FF, 32'h00000000}, // R7
    '{3'd2, 32'h12345678, 5'd3,       32'hF80000FF, 32'h00000000}  // R5 system
  };

  task automatic idle();
    flg_upd = 0; flg_nzcv = 0; flg_qset = 0; mv_we = 0; mv_saved = 0;
    mv_fields = 0; mv_data = 0; exc_entry = 0; exc_mode = 0; exc_ret = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    idle();
    case (v.op)
      3'd0: begin flg_upd = 1; flg_nzcv = v.a[3:0]; flg_qset = v.b[0]; end
      3'd1: begin mv_we = 1; mv_data = v.a; mv_fields = v.b[1:0]; end
      3'd2: begin mv_we = 1; mv_saved = 1; mv_data = v.a; mv_fields = v.b[1:0]; end
      3'd3: begin exc_entry = 1; exc_mode = v.b; end
      default: exc_ret = 1;
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset live", status_o, 32'h000000D3);
    chk("R2 reset saved", saved_o, 32'h0);
    chk("R9 reset enables", {30'd0, irq_en, fiq_en}, 32'h0);

    foreach (VECS[i]) begin
      apply(VECS[i]);
      chk($sformatf("R1/R3-R8 vec%0d live", i), status_o, VECS[i].exp_s);
      chk($sformatf("R8 vec%0d saved", i), saved_o, VECS[i].exp_sv);
      chk($sformatf("R9 vec%0d enables", i), {30'd0, irq_en, fiq_en},
          {30'd0, ~VECS[i].exp_s[7], ~VECS[i].exp_s[6]});
    end

    // R10: entry and flag update together; entry wins, flags unchanged
    @(negedge clk);
    exc_entry = 1; exc_mode = 5'b10011; flg_upd = 1; flg_nzcv = 4'h0;
    @(negedge clk);
    idle();
    chk("R10 entry over flag live", status_o, 32'hF80000D3);
    chk("R10 entry over flag saved", saved_o, 32'hF80000FF);

    // R10: return and move together; return wins
    @(negedge clk);
    exc_ret = 1; mv_we = 1; mv_fields = 2'b11; mv_data = 32'h0;
    @(negedge clk);
    idle();
    chk("R10 return over move", status_o, 32'hF80000FF);

    // R2: reset mid-run clears banks
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 rereset live", status_o, 32'h000000D3);
    chk("R2 rereset saved", saved_o, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule